// File: doc/BRIEF.md
# Burst Transmit Enable Sequencer

This block paces a time-division transmitter. It holds the transmit-enable line high for a programmed number of clock cycles, which is the burst. It then holds the line low for a second programmed number of cycles, which is the guard gap, and repeats this for as long as it is told to run.

Every gap is also a reconfiguration window. The block keeps up to eight banks of fifteen configuration words. During each gap it copies the next bank, one word per clock, into a set of active registers that feed the rest of the transmit path. Consecutive bursts can therefore use different settings, for example a different filter coefficient bank.

An optional gain table shapes the edges of each burst. The table is walked forward as the burst starts and backward as it ends, and the gain sits at full scale in between. With the table disabled, the gain output is a fixed full-scale value. All counts, banks and table entries are loaded through one simple write port.

Top module: `tx_burst_seq`

## Requirements
- R1: After reset, `txen` is 0, `cur_set` is 0, every active slot is 0 and `gain` is full scale (all ones), since the profile is off.
- R2: A write that sets the run bit (target 0, address 3, bit 0) while idle is followed by one idle cycle. Then `txen` stays low for exactly the programmed gap length (target 0, address 1), then goes high.
- R3: While run stays set, `txen` alternates between exactly the burst length (target 0, address 0) of high cycles and exactly the gap length of low cycles.
- R4: Clearing the run bit during a burst lets that burst finish at its full length. After it, `txen` stays low.
- R5: In gap cycle k (counting from 0), slot k of the selected bank is copied into active slot k, for k from 0 to 14. Active slot k occupies `active_cfg[16k+15:16k]`. The active slots do not change while `txen` is high.
- R6: The first burst after a start uses bank 0. Each gap selects the next bank, and the bank after the last one (target 0, address 2 holds the bank count minus 1) is bank 0. `cur_set` is stable during a burst.
- R7: With the profile bit set (target 0, address 3, bit 1), `gain` in burst cycle c of a burst of length N is entry min(c, N-1-c) of the gain table when that index is below the table depth. Otherwise it is full scale.
- R8: With the profile bit set, `gain` is 0 whenever `txen` is low.
- R9: With the profile bit clear, `gain` is full scale on every cycle.
- R10: Write target 1 stores bank word data[15:0] at address bits [6:4] = bank and [3:0] = slot. Write target 2 stores data[13:0] as gain table entry number `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the programming port |
| wr_tgt | input | 2 | Write target: 0 control, 1 bank storage, 2 gain table |
| wr_addr | input | 8 | Register, bank word or table address |
| wr_data | input | 32 | Write data |
| txen | output | 1 | Transmit enable, high during a burst |
| cur_set | output | 3 | Bank selected for the current gap and burst |
| active_cfg | output | 240 | Fifteen active configuration words, slot 0 in the low bits |
| gain | output | 14 | Ramp gain value |

## Verification
A wrong burst or gap counter shows as a wrong `txen` run length at the very next edge of `txen`. A wrong bank pointer shows in `cur_set` and in the words that land in the active slots during the gap it selects. A wrong transfer index shows as a slot that differs from the expected mix of old and new bank words within one gap cycle. A wrong ramp index shows as a wrong `gain` value in the same burst cycle, so the rising and falling edges of each burst are compared cycle by cycle, including a burst short enough that the two ramps meet.

// File: rtl/bseq_pkg.sv
// Shared types and address constants for the burst transmit sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package bseq_pkg;

    // Sequencer phase: idle, guard gap (txen low), burst (txen high)
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

    // Write-port targets
    localparam logic [1:0] TGT_CTRL = 2'd0;
    localparam logic [1:0] TGT_CFG  = 2'd1;
    localparam logic [1:0] TGT_GAIN = 2'd2;

    // Control register addresses inside TGT_CTRL
    localparam int CTRL_ON   = 0;
    localparam int CTRL_OFF  = 1;
    localparam int CTRL_LAST = 2;
    localparam int CTRL_MODE = 3;

endpackage

// File: rtl/bseq_ctrl_regs.sv
// Control registers for the sequencer: burst length, gap length,
// last bank index, run bit and ramp-profile bit.
// Assumes: counts are written while the sequencer is idle.
module bseq_ctrl_regs
    import bseq_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int SET_W   = 3,
    parameter int ADDR_W  = 8,
    parameter int WR_W    = 32,
    parameter int GAP_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic [CNT_W-1:0]  on_len,
    output logic [CNT_W-1:0]  off_len,
    output logic [SET_W-1:0]  last_set,
    output logic              run,
    output logic              gain_en
);

    logic ctrl_hit;
    logic unused_bits;

    assign ctrl_hit    = wr_en && (wr_tgt == TGT_CTRL);
    assign unused_bits = ^wr_data[WR_W-1:CNT_W];

    // Register update from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_len   <= CNT_W'(1);
            off_len  <= CNT_W'(GAP_RST);
            last_set <= '0;
            run      <= 1'b0;
            gain_en  <= 1'b0;
        end else if (ctrl_hit) begin
            if (wr_addr == ADDR_W'(CTRL_ON))   on_len   <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(CTRL_OFF))  off_len  <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(CTRL_LAST)) last_set <= wr_data[SET_W-1:0];
            if (wr_addr == ADDR_W'(CTRL_MODE)) begin
                run     <= wr_data[0];
                gain_en <= wr_data[1];
            end
        end
    end

endmodule

// File: rtl/bseq_timer.sv
// Burst/gap timer: walks idle -> gap -> burst -> gap ... and advances the
// bank pointer at the end of every burst that is followed by another gap.
// Assumes: on_len >= 1 and off_len >= the number of slots per bank.
module bseq_timer
    import bseq_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int SET_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    input  logic [SET_W-1:0] last_set,
    input  logic             run,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic [SET_W-1:0] set_idx
);

    logic [CNT_W:0] cnt_nx;
    logic           gap_done;
    logic           burst_done;

    assign cnt_nx     = {1'b0, cnt} + (CNT_W+1)'(1);
    assign gap_done   = cnt_nx >= {1'b0, off_len};
    assign burst_done = cnt_nx >= {1'b0, on_len};

    // Phase, cycle counter and bank pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            set_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (run) begin
                        state   <= ST_GAP;
                        cnt     <= '0;
                        set_idx <= '0;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        state <= ST_BURST;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_nx[CNT_W-1:0];
                    end
                end
                ST_BURST: begin
                    if (burst_done) begin
                        cnt <= '0;
                        if (run) begin
                            state   <= ST_GAP;
                            set_idx <= (set_idx >= last_set) ? '0
                                                             : set_idx + SET_W'(1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt_nx[CNT_W-1:0];
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bseq_cfg_bank.sv
// Bank storage for NUM_SETS configuration sets of REGS words, plus the
// active register file loaded one slot per clock during each gap.
// Assumes: write address holds the slot in the low SLOT_W bits and the
// bank right above; storage itself is not reset.
module bseq_cfg_bank
    import bseq_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int REGS     = 15,
    parameter int REG_W    = 16,
    parameter int SET_W    = 3,
    parameter int CNT_W    = 20,
    parameter int ADDR_W   = 8,
    parameter int WR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_tgt,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WR_W-1:0]         wr_data,
    input  seq_state_e              state,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [SET_W-1:0]        set_idx,
    output logic [REGS*REG_W-1:0]   active_cfg
);

    localparam int SLOT_W = $clog2(REGS);

    logic [REG_W-1:0]  store [NUM_SETS][REGS];
    logic [SET_W-1:0]  w_set;
    logic [SLOT_W-1:0] w_slot;
    logic              unused_bits;

    assign w_set       = wr_addr[SLOT_W +: SET_W];
    assign w_slot      = wr_addr[SLOT_W-1:0];
    assign unused_bits = ^{wr_addr[ADDR_W-1:SLOT_W+SET_W], wr_data[WR_W-1:REG_W]};

    // Bank storage write
    always_ff @(posedge clk) begin
        if (wr_en && (wr_tgt == TGT_CFG) && (w_slot < SLOT_W'(REGS)))
            store[w_set][w_slot] <= wr_data[REG_W-1:0];
    end

    for (genvar k = 0; k < REGS; k++) begin : g_slot
        logic [REG_W-1:0] act;

        // Load slot k in gap cycle k from the selected bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                act <= '0;
            else if ((state == ST_GAP) && (cnt == CNT_W'(k)))
                act <= store[set_idx][k];
        end

        assign active_cfg[k*REG_W +: REG_W] = act;
    end

endmodule

// File: rtl/bseq_gain_ramp.sv
// Gain ramp: table walked forward from the burst start and backward
// toward the burst end, full scale in between, zero outside bursts.
// Assumes: GAIN_DEPTH < 2**ADDR_W and GAIN_DEPTH >= 2; table not reset.
module bseq_gain_ramp
    import bseq_pkg::*;
#(
    parameter int GAIN_W     = 14,
    parameter int GAIN_DEPTH = 192,
    parameter int CNT_W      = 20,
    parameter int ADDR_W     = 8,
    parameter int WR_W       = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [1:0]        wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  on_len,
    input  logic              gain_en,
    output logic [GAIN_W-1:0] gain
);

    localparam int IDX_W = $clog2(GAIN_DEPTH);
    localparam logic [GAIN_W-1:0] FULL = '1;

    logic [GAIN_W-1:0] tbl [GAIN_DEPTH];
    logic [CNT_W-1:0]  to_end;
    logic [CNT_W-1:0]  idx;
    logic              unused_bits;

    assign unused_bits = ^wr_data[WR_W-1:GAIN_W];

    // Gain table write
    always_ff @(posedge clk) begin
        if (wr_en && (wr_tgt == TGT_GAIN) && (wr_addr < ADDR_W'(GAIN_DEPTH)))
            tbl[wr_addr[IDX_W-1:0]] <= wr_data[GAIN_W-1:0];
    end

    // Distance to the nearer burst edge selects the table entry
    always_comb begin
        to_end = on_len - cnt - CNT_W'(1);
        idx    = (cnt < to_end) ? cnt : to_end;
        if (!gain_en)
            gain = FULL;
        else if (state != ST_BURST)
            gain = '0;
        else if (idx < CNT_W'(GAIN_DEPTH))
            gain = tbl[idx[IDX_W-1:0]];
        else
            gain = FULL;
    end

endmodule

// File: rtl/tx_burst_seq.sv
// Top of the burst transmit sequencer: write port, timer, bank transfer
// and gain ramp. txen is the registered burst phase.
// Assumes: control values are programmed before the run bit is set.
module tx_burst_seq
    import bseq_pkg::*;
#(
    parameter int NUM_SETS   = 8,
    parameter int REGS       = 15,
    parameter int REG_W      = 16,
    parameter int CNT_W      = 20,
    parameter int GAIN_W     = 14,
    parameter int GAIN_DEPTH = 192,
    parameter int ADDR_W     = 8,
    parameter int WR_W       = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_tgt,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WR_W-1:0]               wr_data,
    output logic                          txen,
    output logic [$clog2(NUM_SETS)-1:0]   cur_set,
    output logic [REGS*REG_W-1:0]         active_cfg,
    output logic [GAIN_W-1:0]             gain
);

    localparam int SET_W = $clog2(NUM_SETS);

    logic [CNT_W-1:0] on_len;
    logic [CNT_W-1:0] off_len;
    logic [SET_W-1:0] last_set;
    logic             run;
    logic             gain_en;
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [SET_W-1:0] set_idx;

    bseq_ctrl_regs #(
        .CNT_W(CNT_W), .SET_W(SET_W), .ADDR_W(ADDR_W), .WR_W(WR_W), .GAP_RST(REGS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .on_len(on_len), .off_len(off_len), .last_set(last_set),
        .run(run), .gain_en(gain_en)
    );

    bseq_timer #(.CNT_W(CNT_W), .SET_W(SET_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .on_len(on_len), .off_len(off_len),
        .last_set(last_set), .run(run),
        .state(state), .cnt(cnt), .set_idx(set_idx)
    );

    bseq_cfg_bank #(
        .NUM_SETS(NUM_SETS), .REGS(REGS), .REG_W(REG_W), .SET_W(SET_W),
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .WR_W(WR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .state(state), .cnt(cnt), .set_idx(set_idx), .active_cfg(active_cfg)
    );

    bseq_gain_ramp #(
        .GAIN_W(GAIN_W), .GAIN_DEPTH(GAIN_DEPTH), .CNT_W(CNT_W),
        .ADDR_W(ADDR_W), .WR_W(WR_W)
    ) u_ramp (
        .clk(clk), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .state(state), .cnt(cnt), .on_len(on_len),
        .gain_en(gain_en), .gain(gain)
    );

    assign txen    = (state == ST_BURST);
    assign cur_set = set_idx;

endmodule

// File: rtl/bseq_checker.sv
// Property checker for tx_burst_seq, attached through bind.
// Assumes: burst length is not changed while a burst is running.
module bseq_checker #(
    parameter int NUM_SETS = 8,
    parameter int REGS     = 15,
    parameter int REG_W    = 16,
    parameter int CNT_W    = 20,
    parameter int GAIN_W   = 14
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          txen,
    input logic [$clog2(NUM_SETS)-1:0]   cur_set,
    input logic [REGS*REG_W-1:0]         active_cfg,
    input logic [GAIN_W-1:0]             gain,
    input logic [CNT_W-1:0]              on_len,
    input logic                          gain_en
);

    localparam int SET_W = $clog2(NUM_SETS);

    logic [CNT_W:0] hi_run;
    logic [CNT_W:0] lo_run;

    // Lengths of the current high and low runs of txen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= txen ? hi_run + (CNT_W+1)'(1) : '0;
            if (txen)
                lo_run <= '0;
            else if (lo_run != '1)
                lo_run <= lo_run + (CNT_W+1)'(1);
        end
    end

    a_r3_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txen) |-> hi_run == {1'b0, on_len});

    a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        txen |-> hi_run < {1'b0, on_len});

    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && $past(txen)) |-> $stable(active_cfg));

    a_r5_gap_room: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen) |-> lo_run >= (CNT_W+1)'(REGS));

    a_r6_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
        txen |-> $stable(cur_set));

    a_r6_set_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txen) |-> (cur_set == $past(cur_set) + SET_W'(1)) ||
                        (cur_set == '0) || (cur_set == $past(cur_set)));

    a_r8_quiet_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_en && !txen) |-> gain == '0);

    a_r9_flat_gain: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_en |-> gain == '1);

endmodule

bind tx_burst_seq bseq_checker #(
    .NUM_SETS(NUM_SETS), .REGS(REGS), .REG_W(REG_W), .CNT_W(CNT_W), .GAIN_W(GAIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .txen(txen), .cur_set(cur_set),
    .active_cfg(active_cfg), .gain(gain), .on_len(on_len), .gain_en(gain_en)
);

// File: tb/tb_tx_burst_seq.sv
// Self-checking bench: three run phases with different bank counts,
// lengths and ramp settings, every burst and gap checked cycle by cycle.
module tb_tx_burst_seq;

    localparam int NUM_SETS   = 8;
    localparam int REGS       = 15;
    localparam int REG_W      = 16;
    localparam int CNT_W      = 20;
    localparam int GAIN_W     = 14;
    localparam int GAIN_DEPTH = 4;
    localparam int ADDR_W     = 8;
    localparam int WR_W       = 32;
    localparam int SET_W      = $clog2(NUM_SETS);
    localparam int CFG_W      = REGS * REG_W;
    localparam int FULL       = (1 << GAIN_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [1:0]        wr_tgt;
    logic [ADDR_W-1:0] wr_addr;
    logic [WR_W-1:0]   wr_data;
    logic              txen;
    logic [SET_W-1:0]  cur_set;
    logic [CFG_W-1:0]  active_cfg;
    logic [GAIN_W-1:0] gain;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_burst_seq #(
        .NUM_SETS(NUM_SETS), .REGS(REGS), .REG_W(REG_W), .CNT_W(CNT_W),
        .GAIN_W(GAIN_W), .GAIN_DEPTH(GAIN_DEPTH), .ADDR_W(ADDR_W), .WR_W(WR_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_data(wr_data), .txen(txen), .cur_set(cur_set),
        .active_cfg(active_cfg), .gain(gain)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] word_val(int s, int k);
        return REG_W'(s * 256 + k * 16 + 5);
    endfunction

    function automatic logic [CFG_W-1:0] mix(int s_old, int s_new, int j);
        logic [CFG_W-1:0] v;
        for (int k = 0; k < REGS; k++)
            v[k*REG_W +: REG_W] = (k < j) ? word_val(s_new, k) : word_val(s_old, k);
        return v;
    endfunction

    function automatic int tbl_val(int i);
        return 1000 * (i + 1) + 7;
    endfunction

    function automatic int ramp_gain(int c, int on, bit gen);
        int idx;
        if (!gen) return FULL;
        idx = (c < on - 1 - c) ? c : on - 1 - c;
        return (idx < GAIN_DEPTH) ? tbl_val(idx) : FULL;
    endfunction

    task automatic wr(input logic [1:0] t, input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_tgt  = t;
        wr_addr = ADDR_W'(a);
        wr_data = WR_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One run: start, nb bursts, run bit cleared inside the last burst
    task automatic run_phase(input int on, input int off, input int nsets,
                             input int nb, input bit gen);
        int lo;
        int hi;
        int s_cur;
        int s_nxt;
        logic [CFG_W-1:0] held;
        bit stayed_low;
        wr(2'd0, 0, on);
        wr(2'd0, 1, off);
        wr(2'd0, 2, nsets - 1);
        wr(2'd0, 3, {30'd0, gen, 1'b1});
        lo = 0;
        while (!txen && lo < off + 10) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == off + 1, "R2", "start delay", lo, off + 1);
        for (int b = 0; b < nb; b++) begin
            s_cur = b % nsets;
            s_nxt = (b + 1) % nsets;
            chk(cur_set == SET_W'(s_cur), "R6", "bank at burst", cur_set, s_cur);
            chk(active_cfg == mix(s_cur, s_cur, REGS), "R10", "bank image",
                active_cfg, mix(s_cur, s_cur, REGS));
            held = active_cfg;
            hi = 0;
            while (txen && hi < on + 10) begin
                chk(int'(gain) == ramp_gain(hi, on, gen), gen ? "R7" : "R9",
                    "burst gain", gain, ramp_gain(hi, on, gen));
                chk(active_cfg == held, "R5", "hold in burst", active_cfg, held);
                if (b == nb - 1 && hi == 1) begin
                    wr_en   = 1'b1;
                    wr_tgt  = 2'd0;
                    wr_addr = ADDR_W'(3);
                    wr_data = WR_W'({gen, 1'b0});
                end
                if (b == nb - 1 && hi == 2) wr_en = 1'b0;
                hi++;
                @(negedge clk);
            end
            if (b < nb - 1) begin
                chk(hi == on, "R3", "burst length", hi, on);
                lo = 0;
                while (!txen && lo < off + 10) begin
                    chk(int'(gain) == (gen ? 0 : FULL), gen ? "R8" : "R9",
                        "gap gain", gain, gen ? 0 : FULL);
                    chk(cur_set == SET_W'(s_nxt), "R6", "bank in gap", cur_set, s_nxt);
                    chk(active_cfg == mix(s_cur, s_nxt, lo), "R5", "slot transfer",
                        active_cfg, mix(s_cur, s_nxt, lo));
                    lo++;
                    @(negedge clk);
                end
                chk(lo == off, "R3", "gap length", lo, off);
            end else begin
                chk(hi == on, "R4", "last burst length", hi, on);
                stayed_low = 1'b1;
                for (int i = 0; i < 2 * (on + off); i++) begin
                    if (txen) stayed_low = 1'b0;
                    @(negedge clk);
                end
                chk(stayed_low, "R4", "low after stop", !stayed_low, 0);
                chk(int'(gain) == (gen ? 0 : FULL), gen ? "R8" : "R9",
                    "idle gain", gain, gen ? 0 : FULL);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_tgt  = '0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txen == 1'b0, "R1", "txen", txen, 0);
        chk(cur_set == '0, "R1", "cur_set", cur_set, 0);
        chk(active_cfg == '0, "R1", "active slots", active_cfg, 0);
        chk(int'(gain) == FULL, "R1", "gain", gain, FULL);
        // R10 program all banks and the gain table
        for (int s = 0; s < NUM_SETS; s++)
            for (int k = 0; k < REGS; k++)
                wr(2'd1, s * 16 + k, int'(word_val(s, k)));
        for (int i = 0; i < GAIN_DEPTH; i++)
            wr(2'd2, i, tbl_val(i));
        // flat gain, three banks
        run_phase(12, 16, 3, 5, 1'b0);
        // ramped gain with flat middle, all eight banks and wrap
        run_phase(20, 16, 8, 9, 1'b1);
        // short burst where the ramps meet, one bank, minimum gap
        run_phase(5, 15, 1, 3, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule